// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

An 8-bit timer/counter with a waveform generator that drives one compare output pin. A 3-bit mode code selects how the counter sequences and where its TOP comes from: free-running normal count, clear-on-compare (CTC), single-slope fast PWM, or dual-slope phase-correct PWM. TOP is either the full-scale value 0xFF or the active value of compare register A. A 2-bit output code sets what compare B does to the pin in the selected mode.

Both compare registers are double buffered. A write always lands in a holding register. In normal and CTC modes the active value follows the write at once. In fast PWM it is copied at the wrap to BOTTOM, and in phase-correct PWM at TOP. The counter steps only on cycles where the count-enable tick is high. It reports an overflow strobe and a compare-B match strobe, each one cycle wide and issued on the cycle after the tick that caused it.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0x00, the mode code is 0 (normal), the output code is 00, both compare registers are 0, and `oc_b_o`, `ovf_o` and `cmpb_o` are low.
- R2: The count changes only on clock edges where `tick_i` is high. Mode codes 4 and 6 are reserved: the count holds and the pin is disconnected.
- R3: Mode 0 counts 0x00 to 0xFF and wraps. Mode 2 (CTC) goes to 0x00 on the tick taken at a count equal to compare A. Modes 3 and 7 (fast PWM) go to 0x00 on the tick taken at TOP, where TOP is 0xFF for mode 3 and compare A for mode 7.
- R4: Modes 1 and 5 (phase-correct, TOP 0xFF and compare A respectively) count up from 0x00 to TOP and then down to 0x00, reversing at each end. The full period is 2*TOP ticks.
- R5: `ovf_o` pulses for one cycle after a tick taken at count 0xFF in modes 0 and 2, at TOP in fast PWM, and at 0x00 while counting down in phase-correct mode.
- R6: Compare writes become active at once in modes 0 and 2 and in the reserved modes. In fast PWM they become active on the tick that wraps to 0x00, and in phase-correct mode on the tick taken at TOP.
- R7: In modes 0 and 2 a compare-B match (a tick taken at a count equal to compare B) toggles the pin for output code 01, clears it for 10 and sets it for 11.
- R8: In fast PWM, output code 10 clears the pin on a match and sets it at the wrap to 0x00. Code 11 does the opposite. When compare B equals TOP, the wrap action wins.
- R9: In phase-correct mode, output code 10 clears the pin on a match while stepping up and sets it on a match while stepping down. Code 11 does the opposite.
- R10: In phase-correct mode with compare B equal to TOP and output code 1x, the match is ignored and the pin is forced at TOP: set for 10, cleared for 11. With code 10 the pin therefore stays high after the first TOP.
- R11: With output code 00, or code 01 in either PWM mode, `oc_b_o` shows `port_i` as registered on the previous edge.
- R12: `cmpb_o` pulses for one cycle after any tick taken at a count equal to the active compare B, in every mode except the reserved ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable |
| mode_we_i | input | 1 | Write strobe for the mode code |
| mode_i | input | 3 | Mode code |
| com_we_i | input | 1 | Write strobe for the output code |
| com_i | input | 2 | Compare-B output code |
| ocra_we_i | input | 1 | Write strobe for compare A |
| ocra_i | input | 8 | Compare A value |
| ocrb_we_i | input | 1 | Write strobe for compare B |
| ocrb_i | input | 8 | Compare B value |
| port_i | input | 1 | Pin value used while disconnected |
| cnt_o | output | 8 | Current count |
| oc_b_o | output | 1 | Compare output pin |
| ovf_o | output | 1 | Overflow strobe |
| cmpb_o | output | 1 | Compare-B match strobe |

## Verification
A wrong count or a wrong direction bit shows on `cnt_o` on the next tick, and the sequence checks at TOP and BOTTOM catch it within one period. A compare value loaded too early or too late changes where the pin flips. The bench writes compare values in the middle of a period and watches the pin before the next update point, so such a fault shows within one period. Duty is measured as high samples over whole periods, which exposes a mis-coded output action or a missed special case within two periods. Overflow and match strobes are counted over exact windows, so an extra or a missing strobe shows in the same period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    K_NORMAL,
    K_CTC,
    K_FAST,
    K_PHASE,
    K_HOLD
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  top_a;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [2:0] m);
    mode_cfg_t c;
    c.kind  = K_HOLD;
    c.top_a = 1'b0;
    case (m)
      3'd0: c.kind = K_NORMAL;
      3'd1: c.kind = K_PHASE;
      3'd2: begin c.kind = K_CTC;   c.top_a = 1'b1; end
      3'd3: c.kind = K_FAST;
      3'd5: begin c.kind = K_PHASE; c.top_a = 1'b1; end
      3'd7: begin c.kind = K_FAST;  c.top_a = 1'b1; end
      default: c.kind = K_HOLD;
    endcase
    return c;
  endfunction

  function automatic logic is_immediate(input kind_e k);
    return (k == K_NORMAL) || (k == K_CTC) || (k == K_HOLD);
  endfunction

endpackage

// File: rtl/pwm_ocr_buf.sv
module pwm_ocr_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         imm_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);

  logic [W-1:0] hold_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i) hold_q <= wdata_i;
      if (imm_i)       act_q <= we_i ? wdata_i : hold_q;
      else if (load_i) act_q <= hold_q;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/pwm_cnt_unit.sv
module pwm_cnt_unit
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  kind_e        kind_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         dn_o,
  output logic         step_dn_o,
  output logic         hit_top_o,
  output logic         ovf_evt_o,
  output logic         upd_evt_o
);

  localparam logic [W-1:0] MAX_V = '1;
  localparam logic [W-1:0] BOT_V = '0;
  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d, step_dn;
  logic         hit_top;

  assign hit_top = (cnt_q == top_i);

  always_comb begin
    cnt_d   = cnt_q;
    dn_d    = 1'b0;
    step_dn = 1'b0;
    case (kind_i)
      K_NORMAL: cnt_d = cnt_q + ONE_V;
      K_CTC, K_FAST: cnt_d = hit_top ? BOT_V : cnt_q + ONE_V;
      K_PHASE: begin
        // reverse at TOP going up, at BOTTOM going down
        step_dn = dn_q ? (cnt_q != BOT_V) : hit_top;
        dn_d    = step_dn;
        if (step_dn) cnt_d = (cnt_q == BOT_V) ? BOT_V : cnt_q - ONE_V;
        else         cnt_d = cnt_q + ONE_V;
      end
      default: begin
        cnt_d = cnt_q;
        dn_d  = dn_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  always_comb begin
    ovf_evt_o = 1'b0;
    upd_evt_o = 1'b0;
    case (kind_i)
      K_NORMAL, K_CTC: ovf_evt_o = tick_i && (cnt_q == MAX_V);
      K_FAST: begin
        ovf_evt_o = tick_i && hit_top;
        upd_evt_o = tick_i && hit_top;
      end
      K_PHASE: begin
        ovf_evt_o = tick_i && dn_q && (cnt_q == BOT_V);
        upd_evt_o = tick_i && hit_top && !dn_q;
      end
      default: ;
    endcase
  end

  assign cnt_o     = cnt_q;
  assign dn_o      = dn_q;
  assign step_dn_o = step_dn;
  assign hit_top_o = hit_top;

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  kind_e        kind_i,
  input  logic [1:0]   com_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ocrb_i,
  input  logic [W-1:0] top_i,
  input  logic         step_dn_i,
  input  logic         hit_top_i,
  input  logic         port_i,
  output logic         oc_o,
  output logic         match_o
);

  logic oc_q, oc_d, port_q, match, linked;

  assign match = tick_i && (cnt_i == ocrb_i) && (kind_i != K_HOLD);

  always_comb begin
    case (kind_i)
      K_NORMAL, K_CTC: linked = (com_i != 2'b00);
      K_FAST, K_PHASE: linked = com_i[1];
      default:         linked = 1'b0;
    endcase
  end

  always_comb begin
    oc_d = oc_q;
    case (kind_i)
      K_NORMAL, K_CTC: begin
        if (match) begin
          case (com_i)
            2'b01:   oc_d = !oc_q;
            2'b10:   oc_d = 1'b0;
            2'b11:   oc_d = 1'b1;
            default: oc_d = oc_q;
          endcase
        end
      end
      K_FAST: begin
        if (com_i[1]) begin
          if (tick_i && hit_top_i) oc_d = !com_i[0];
          else if (match)          oc_d = com_i[0];
        end
      end
      K_PHASE: begin
        if (com_i[1]) begin
          if (ocrb_i == top_i) begin
            // match ignored; action forced at TOP
            if (tick_i && hit_top_i && step_dn_i) oc_d = !com_i[0];
          end else if (match) begin
            oc_d = step_dn_i ? !com_i[0] : com_i[0];
          end
        end
      end
      default: oc_d = oc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q   <= 1'b0;
      port_q <= 1'b0;
    end else begin
      oc_q   <= oc_d;
      port_q <= port_i;
    end
  end

  assign oc_o    = linked ? oc_q : port_q;
  assign match_o = match;

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         mode_we_i,
  input  logic [2:0]   mode_i,
  input  logic         com_we_i,
  input  logic [1:0]   com_i,
  input  logic         ocra_we_i,
  input  logic [W-1:0] ocra_i,
  input  logic         ocrb_we_i,
  input  logic [W-1:0] ocrb_i,
  input  logic         port_i,
  output logic [W-1:0] cnt_o,
  output logic         oc_b_o,
  output logic         ovf_o,
  output logic         cmpb_o
);

  localparam int unsigned NCMP  = 2;
  localparam logic [W-1:0] MAX_V = '1;

  logic [2:0]   mode_q;
  logic [1:0]   com_q;
  mode_cfg_t    cfg;
  logic         imm;
  logic [W-1:0] top_val;
  logic         dn, step_dn, hit_top, ovf_evt, upd_evt, match;
  logic         ovf_q, cmpb_q;

  logic [NCMP-1:0]        cmp_we;
  logic [NCMP-1:0][W-1:0] cmp_wd;
  logic [NCMP-1:0][W-1:0] cmp_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      com_q  <= '0;
      ovf_q  <= 1'b0;
      cmpb_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      if (com_we_i)  com_q  <= com_i;
      ovf_q  <= ovf_evt;
      cmpb_q <= match;
    end
  end

  assign cfg     = decode_mode(mode_q);
  assign imm     = is_immediate(cfg.kind);
  assign top_val = cfg.top_a ? cmp_act[0] : MAX_V;

  assign cmp_we = {ocrb_we_i, ocra_we_i};
  assign cmp_wd = {ocrb_i, ocra_i};

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    pwm_ocr_buf #(.W(W)) i_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cmp_we[g]),
      .wdata_i(cmp_wd[g]),
      .imm_i  (imm),
      .load_i (upd_evt),
      .act_o  (cmp_act[g])
    );
  end

  pwm_cnt_unit #(.W(W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kind_i   (cfg.kind),
    .top_i    (top_val),
    .cnt_o    (cnt_o),
    .dn_o     (dn),
    .step_dn_o(step_dn),
    .hit_top_o(hit_top),
    .ovf_evt_o(ovf_evt),
    .upd_evt_o(upd_evt)
  );

  pwm_wave_gen #(.W(W)) i_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kind_i   (cfg.kind),
    .com_i    (com_q),
    .cnt_i    (cnt_o),
    .ocrb_i   (cmp_act[1]),
    .top_i    (top_val),
    .step_dn_i(step_dn),
    .hit_top_i(hit_top),
    .port_i   (port_i),
    .oc_o     (oc_b_o),
    .match_o  (match)
  );

  assign ovf_o  = ovf_q;
  assign cmpb_o = cmpb_q;

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic [W-1:0] cnt_o,
  input logic         ovf_o,
  input logic         cmpb_o,
  input kind_e        kind,
  input logic [W-1:0] top_val,
  input logic         dn
);

  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !tick_i |=> $stable(cnt_o));

  assert_normal_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (kind == K_NORMAL && tick_i) |=> (cnt_o == $past(cnt_o) + ONE_V));

  assert_ctc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (kind == K_CTC && tick_i && cnt_o == top_val) |=> (cnt_o == '0));

  assert_fast_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (kind == K_FAST && tick_i && cnt_o == top_val) |=> (cnt_o == '0));

  assert_phase_turn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (kind == K_PHASE && tick_i && !dn && cnt_o == top_val && top_val != '0)
      |=> (cnt_o == $past(cnt_o) - ONE_V));

  assert_ovf_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ovf_o |-> $past(tick_i));

  assert_cmpb_on_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    cmpb_o |-> $past(tick_i));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .cnt_o  (cnt_o),
  .ovf_o  (ovf_o),
  .cmpb_o (cmpb_o),
  .kind   (cfg.kind),
  .top_val(top_val),
  .dn     (dn)
);

// File: tb/test_pwm_timer8.sv
`timescale 1ns/1ps
module test_pwm_timer8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic       com_we_i = 1'b0;
  logic [1:0] com_i = '0;
  logic       ocra_we_i = 1'b0;
  logic [7:0] ocra_i = '0;
  logic       ocrb_we_i = 1'b0;
  logic [7:0] ocrb_i = '0;
  logic       port_i = 1'b0;
  logic [7:0] cnt_o;
  logic       oc_b_o, ovf_o, cmpb_o;

  int n_chk = 0;
  int n_bad = 0;
  int hi_n, ovf_n, cmp_n;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_timer8 i_pwm_timer8 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    tick_i = 1'b0; port_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input int sel, input int val);
    tick_i = 1'b0;
    case (sel)
      0: begin mode_we_i = 1'b1; mode_i = 3'(val); end
      1: begin com_we_i  = 1'b1; com_i  = 2'(val); end
      2: begin ocra_we_i = 1'b1; ocra_i = 8'(val); end
      default: begin ocrb_we_i = 1'b1; ocrb_i = 8'(val); end
    endcase
    @(negedge clk_i);
    mode_we_i = 1'b0; com_we_i = 1'b0; ocra_we_i = 1'b0; ocrb_we_i = 1'b0;
  endtask

  task automatic run(input int n);
    hi_n = 0; ovf_n = 0; cmp_n = 0;
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      hi_n  += int'(oc_b_o);
      ovf_n += int'(ovf_o);
      cmp_n += int'(cmpb_o);
    end
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 oc", int'(oc_b_o), 0);
    chk("R1 flags", int'(ovf_o) + int'(cmpb_o), 0);
  endtask

  task automatic t_normal();
    do_reset();
    run(255);
    chk("R3 normal count", int'(cnt_o), 255);
    chk("R5 no early ovf", ovf_n, 0);
    run(1);
    chk("R3 normal wrap", int'(cnt_o), 0);
    chk("R5 ovf at MAX", int'(ovf_o), 1);
    run(1);
    chk("R5 ovf one cycle", int'(ovf_o), 0);
    tick_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R2 hold without tick", int'(cnt_o), 1);
  endtask

  task automatic t_match_flag();
    do_reset();
    wr(3, 5);
    run(5);
    chk("R12 no early match", cmp_n, 0);
    run(1);
    chk("R12 match strobe", int'(cmpb_o), 1);
    wr(1, 3);
    wr(3, 2);
    run(253);
    chk("R7 set on match", int'(oc_b_o), 1);
    wr(1, 2);
    run(256);
    chk("R7 clear on match", int'(oc_b_o), 0);
  endtask

  task automatic t_ctc();
    do_reset();
    wr(2, 9); wr(3, 3); wr(1, 1); wr(0, 2);
    run(4);
    chk("R7 toggle high", int'(oc_b_o), 1);
    run(10);
    chk("R3 ctc period", int'(cnt_o), 4);
    chk("R7 toggle low", int'(oc_b_o), 0);
    chk("R5 ctc no ovf", ovf_n, 0);
    wr(3, 6);
    run(3);
    chk("R6 ctc immediate", int'(oc_b_o), 1);
  endtask

  task automatic t_fast();
    do_reset();
    wr(3, 100); wr(1, 2); wr(0, 3);
    run(256);
    run(256);
    chk("R8 fast duty 10", hi_n, 101);
    chk("R5 fast ovf", ovf_n, 1);
    run(10);
    wr(3, 50);
    run(90);
    chk("R6 fast buffered", int'(oc_b_o), 1);
    run(156);
    run(256);
    chk("R6 fast new duty", hi_n, 51);
    wr(1, 3);
    run(256);
    run(256);
    chk("R8 fast duty 11", hi_n, 205);
  endtask

  task automatic t_fast_top_a();
    do_reset();
    wr(2, 99); wr(3, 49); wr(1, 2); wr(0, 7);
    run(100);
    chk("R3 fast top A wrap", int'(cnt_o), 0);
    run(100);
    chk("R8 fast top A duty", hi_n, 50);
    chk("R5 ovf at TOP", ovf_n, 1);
  endtask

  task automatic t_phase();
    do_reset();
    wr(3, 100); wr(1, 2); wr(0, 1);
    run(255);
    chk("R4 phase up to TOP", int'(cnt_o), 255);
    run(1);
    chk("R4 phase turn down", int'(cnt_o), 254);
    run(254);
    chk("R5 no ovf before BOTTOM turn", ovf_n, 0);
    run(510);
    chk("R9 phase duty 10", hi_n, 200);
    chk("R5 phase ovf", ovf_n, 1);
    wr(1, 3);
    run(510);
    run(510);
    chk("R9 phase duty 11", hi_n, 310);
  endtask

  task automatic t_phase_top_a();
    do_reset();
    wr(2, 20); wr(3, 5); wr(1, 2); wr(0, 5);
    run(40);
    run(40);
    chk("R4 phase top A duty", hi_n, 10);
    run(20);
    run(5);
    chk("R4 phase top A down", int'(cnt_o), 15);
    wr(3, 8);
    run(10);
    chk("R6 phase buffered", int'(oc_b_o), 0);
    run(1);
    chk("R6 phase old value set", int'(oc_b_o), 1);
  endtask

  task automatic t_phase_special();
    do_reset();
    wr(2, 20); wr(3, 20); wr(1, 2); wr(0, 5);
    run(40);
    run(40);
    chk("R10 constant high", hi_n, 40);
    wr(1, 3);
    run(40);
    run(40);
    chk("R10 constant low", hi_n, 0);
  endtask

  task automatic t_disconnect();
    do_reset();
    port_i = 1'b1;
    @(negedge clk_i);
    chk("R11 code 00 port", int'(oc_b_o), 1);
    wr(1, 1); wr(0, 3);
    run(300);
    chk("R11 fast code 01 port", hi_n, 300);
    port_i = 1'b0;
    @(negedge clk_i);
    chk("R11 port follows", int'(oc_b_o), 0);
    wr(0, 4);
    port_i = 1'b1;
    run(10);
    chk("R2 reserved hold", int'(cnt_o), int'(8'(300)));
    chk("R2 reserved disconnect", hi_n, 10);
    wr(0, 6);
    run(10);
    chk("R2 reserved 6 hold", int'(cnt_o), int'(8'(300)));
  endtask

  initial begin
    t_reset();
    t_normal();
    t_match_flag();
    t_ctc();
    t_fast();
    t_fast_top_a();
    t_phase();
    t_phase_top_a();
    t_phase_special();
    t_disconnect();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule